// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the device side of a parallel NOR flash model. It watches the host's bus write cycles, each given as a word address, a data word and a write strobe. It recognises the multi-write unlock and command patterns that the flash accepts. When a pattern completes, it sends a single-cycle start pulse and an operation code to the embedded-algorithm engine. It also holds the address and data of the write that completed the pattern. A mode output tells the rest of the model whether reads return array data, whether a command sequence is partly entered, whether an algorithm is running, or whether an erase is suspended.

The engine reports the end of a program or erase through a one-cycle done input. While an algorithm runs, the decoder ignores command writes. The one exception is that an erase accepts a suspend, and a suspended erase accepts a resume. The strobe is sampled on the block clock. A write is accepted only after the strobe has been high for a minimum number of consecutive clocks, so short glitches are dropped. The block does not model the memory array, protection, identification tables or timing of the high-voltage phases.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset, `mode` is 0 (read array), `op_start` is low and `op_code` is 0 (none).
- R2: Four accepted writes start a program: AAh at word address 555h, 55h at 2AAh, A0h at 555h, then any data at any address. The decoder pulses `op_start` for one cycle with `op_code` 1. `op_addr` and `op_data` hold the fourth write's address and full data word, and `mode` becomes 2 (busy).
- R3: Six accepted writes start a chip erase: AAh/555h, 55h/2AAh, 80h/555h, AAh/555h, 55h/2AAh, then 10h/555h. This gives one `op_start` pulse with `op_code` 2 and `mode` 2.
- R4: A sector erase uses the same first five writes as R3, with 30h at any address as the sixth write. This gives one pulse with `op_code` 3, and `op_addr` holds that sixth address.
- R5: While an erase runs (`mode` 2), a write of B0h at any address gives a pulse with `op_code` 4, and `mode` becomes 3 (suspended).
- R6: While suspended, a write of 30h at any address gives a pulse with `op_code` 5, and `mode` returns to 2.
- R7: A one-cycle `alg_done` while `mode` is 2 returns `mode` to 0 on the next cycle.
- R8: While a sequence is partly entered, `mode` is 1. A reset command (F0h, any address) then returns `mode` to 0 without any pulse.
- R9: A write with the wrong address or the wrong data in the middle of a sequence returns `mode` to 0 and starts nothing. A pulse never follows directly from read-array mode.
- R10: During a program, every write is ignored, including B0h. During an erase, every write other than B0h is ignored. While suspended, every write other than 30h is ignored, and so is `alg_done`.
- R11: A strobe high for fewer than MIN_PULSE clocks is not a write. A strobe held high for many clocks counts as exactly one write.
- R12: Command matching compares only data bits [7:0] and the full address width. The upper data bits do not affect decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | Bus write strobe, active high |
| wr_addr | input | ADDR_W | Word address of the bus write |
| wr_data | input | DATA_W | Data of the bus write |
| alg_done | input | 1 | One-cycle end-of-algorithm indication from the engine |
| op_start | output | 1 | One-cycle start pulse |
| op_code | output | 3 | 0 none, 1 program, 2 chip erase, 3 sector erase, 4 suspend, 5 resume |
| op_addr | output | ADDR_W | Address of the write that completed the sequence |
| op_data | output | DATA_W | Data of the write that completed the sequence |
| mode | output | 2 | 0 read array, 1 command entry, 2 busy, 3 suspended |

## Verification
A wrong sequence state appears on `mode` one clock after the write that caused it, so every test reads `mode` right after each write as well as counting start pulses. A decoder stuck in a half-entered sequence shows `mode` 1 where 0 is expected. A dropped lockout shows as an extra start pulse during a program or an erase. A glitch filter that is too loose or too tight moves the number of accepted writes, and the chained sequences that follow make this visible as a missing or extra operation within a few writes.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_PROG   = 3'd1,
        OP_CHIP   = 3'd2,
        OP_SECT   = 3'd3,
        OP_SUSP   = 3'd4,
        OP_RESUME = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        MD_READ = 2'd0,
        MD_CMD  = 2'd1,
        MD_BUSY = 2'd2,
        MD_SUSP = 2'd3
    } mode_e;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_PGM_ARM,
        ST_ERS_ARM,
        ST_ERS_UNL1,
        ST_ERS_UNL2,
        ST_PGM_BUSY,
        ST_ERS_BUSY,
        ST_ERS_SUSP
    } seq_st_e;

    localparam logic [7:0]  KEY_FIRST   = 8'hAA;
    localparam logic [7:0]  KEY_SECOND  = 8'h55;
    localparam logic [7:0]  CODE_WRITE  = 8'hA0;
    localparam logic [7:0]  CODE_ERASE  = 8'h80;
    localparam logic [7:0]  CODE_WHOLE  = 8'h10;
    localparam logic [7:0]  CODE_SECTOR = 8'h30;
    localparam logic [7:0]  CODE_PAUSE  = 8'hB0;
    localparam logic [7:0]  CODE_ABORT  = 8'hF0;
    localparam logic [11:0] KEY_ADDR_HI = 12'h555;
    localparam logic [11:0] KEY_ADDR_LO = 12'h2AA;

    typedef struct packed {
        logic at_hi;
        logic at_lo;
        logic d_first;
        logic d_second;
        logic d_write;
        logic d_erase;
        logic d_whole;
        logic d_sector;
        logic d_pause;
        logic d_abort;
    } cyc_class_t;

    function automatic mode_e mode_of(seq_st_e s);
        case (s)
            ST_READ:                   return MD_READ;
            ST_PGM_BUSY, ST_ERS_BUSY:  return MD_BUSY;
            ST_ERS_SUSP:               return MD_SUSP;
            default:                   return MD_CMD;
        endcase
    endfunction

endpackage

// File: rtl/flash_cmd_strobe_filter.sv
module flash_cmd_strobe_filter
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 21,
    parameter int DATA_W    = 16,
    parameter int MIN_PULSE = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              cyc_vld,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [DATA_W-1:0] cyc_data
);
    localparam int CNT_W = $clog2(MIN_PULSE + 1);
    localparam logic [CNT_W-1:0] CNT_TAKE = CNT_W'(MIN_PULSE - 1);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(MIN_PULSE);

    logic [CNT_W-1:0] hi_cnt;
    logic             take;

    assign take = stb && (hi_cnt == CNT_TAKE);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt   <= '0;
            cyc_vld  <= 1'b0;
            cyc_addr <= '0;
            cyc_data <= '0;
        end else begin
            cyc_vld <= take;
            if (!stb)
                hi_cnt <= '0;
            else if (hi_cnt != CNT_SAT)
                hi_cnt <= hi_cnt + 1'b1;
            if (take) begin
                cyc_addr <= addr;
                cyc_data <= data;
            end
        end
    end

    // A held strobe yields one accepted cycle only (R11)
    assert_one_cycle_per_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        cyc_vld |=> !cyc_vld);
    // An accepted cycle follows a strobe seen high (R11)
    assert_cycle_needs_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        cyc_vld |-> $past(stb));
endmodule

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        code,
    output cyc_class_t        cls
);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(KEY_ADDR_HI);
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(KEY_ADDR_LO);

    always_comb begin
        cls.at_hi    = (addr == A_HI);
        cls.at_lo    = (addr == A_LO);
        cls.d_first  = (code == KEY_FIRST);
        cls.d_second = (code == KEY_SECOND);
        cls.d_write  = (code == CODE_WRITE);
        cls.d_erase  = (code == CODE_ERASE);
        cls.d_whole  = (code == CODE_WHOLE);
        cls.d_sector = (code == CODE_SECTOR);
        cls.d_pause  = (code == CODE_PAUSE);
        cls.d_abort  = (code == CODE_ABORT);
    end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_vld,
    input  cyc_class_t        cls,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [DATA_W-1:0] cyc_data,
    input  logic              alg_done,
    output logic              op_start,
    output op_e               op_code,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output mode_e             mode
);
    seq_st_e st, st_nxt;
    logic    go;
    op_e     go_code;

    always_comb begin
        st_nxt  = st;
        go      = 1'b0;
        go_code = OP_NONE;
        case (st)
            ST_READ:
                if (cyc_vld && cls.d_first && cls.at_hi) st_nxt = ST_UNL1;
            ST_UNL1:
                if (cyc_vld) st_nxt = (cls.d_second && cls.at_lo) ? ST_UNL2 : ST_READ;
            ST_UNL2:
                if (cyc_vld) begin
                    if (cls.d_write && cls.at_hi)      st_nxt = ST_PGM_ARM;
                    else if (cls.d_erase && cls.at_hi) st_nxt = ST_ERS_ARM;
                    else                               st_nxt = ST_READ;
                end
            ST_PGM_ARM:
                if (cyc_vld) begin
                    go = 1'b1; go_code = OP_PROG; st_nxt = ST_PGM_BUSY;
                end
            ST_ERS_ARM:
                if (cyc_vld) st_nxt = (cls.d_first && cls.at_hi) ? ST_ERS_UNL1 : ST_READ;
            ST_ERS_UNL1:
                if (cyc_vld) st_nxt = (cls.d_second && cls.at_lo) ? ST_ERS_UNL2 : ST_READ;
            ST_ERS_UNL2:
                if (cyc_vld) begin
                    if (cls.d_whole && cls.at_hi) begin
                        go = 1'b1; go_code = OP_CHIP; st_nxt = ST_ERS_BUSY;
                    end else if (cls.d_sector) begin
                        go = 1'b1; go_code = OP_SECT; st_nxt = ST_ERS_BUSY;
                    end else begin
                        st_nxt = ST_READ;
                    end
                end
            ST_PGM_BUSY:
                if (alg_done) st_nxt = ST_READ;
            ST_ERS_BUSY:
                if (alg_done) st_nxt = ST_READ;
                else if (cyc_vld && cls.d_pause) begin
                    go = 1'b1; go_code = OP_SUSP; st_nxt = ST_ERS_SUSP;
                end
            ST_ERS_SUSP:
                if (cyc_vld && cls.d_sector) begin
                    go = 1'b1; go_code = OP_RESUME; st_nxt = ST_ERS_BUSY;
                end
            default: st_nxt = ST_READ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_READ;
            op_start <= 1'b0;
            op_code  <= OP_NONE;
            op_addr  <= '0;
            op_data  <= '0;
        end else begin
            st       <= st_nxt;
            op_start <= go;
            if (go) begin
                op_code <= go_code;
                op_addr <= cyc_addr;
                op_data <= cyc_data;
            end
        end
    end

    assign mode = mode_of(st);

    // Start pulses last one cycle (R2)
    assert_start_single_R2: assert property (@(posedge clk) disable iff (rst)
        op_start |=> !op_start);
    // A program start leaves the decoder busy (R2)
    assert_prog_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (op_start && op_code == OP_PROG) |-> mode == MD_BUSY);
    // Suspend enters suspended mode (R5)
    assert_suspend_mode_R5: assert property (@(posedge clk) disable iff (rst)
        (op_start && op_code == OP_SUSP) |-> mode == MD_SUSP);
    // From suspended, only a resume may start (R6)
    assert_resume_only_R6: assert property (@(posedge clk) disable iff (rst)
        (op_start && $past(mode) == MD_SUSP) |-> op_code == OP_RESUME);
    // Done ends a running algorithm (R7)
    assert_done_ends_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_BUSY && alg_done) |=> mode == MD_READ);
    // No pulse straight out of read-array mode (R9)
    assert_no_start_from_read_R9: assert property (@(posedge clk) disable iff (rst)
        op_start |-> $past(mode) != MD_READ);
    // While busy, only a suspend can start anything (R10)
    assert_busy_lockout_R10: assert property (@(posedge clk) disable iff (rst)
        (op_start && $past(mode) == MD_BUSY) |-> op_code == OP_SUSP);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 21,
    parameter int DATA_W    = 16,
    parameter int MIN_PULSE = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              alg_done,
    output logic              op_start,
    output logic [2:0]        op_code,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic [1:0]        mode
);
    logic              cyc_vld;
    logic [ADDR_W-1:0] cyc_addr;
    logic [DATA_W-1:0] cyc_data;
    cyc_class_t        cls;
    op_e               code_q;
    mode_e             mode_q;

    flash_cmd_strobe_filter #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE(MIN_PULSE)
    ) u_filter (
        .clk(clk), .rst(rst), .stb(wr_stb), .addr(wr_addr), .data(wr_data),
        .cyc_vld(cyc_vld), .cyc_addr(cyc_addr), .cyc_data(cyc_data)
    );

    flash_cmd_match #(.ADDR_W(ADDR_W)) u_match (
        .addr(cyc_addr), .code(cyc_data[7:0]), .cls(cls)
    );

    flash_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst(rst), .cyc_vld(cyc_vld), .cls(cls),
        .cyc_addr(cyc_addr), .cyc_data(cyc_data), .alg_done(alg_done),
        .op_start(op_start), .op_code(code_q), .op_addr(op_addr),
        .op_data(op_data), .mode(mode_q)
    );

    assign op_code = code_q;
    assign mode    = mode_q;
endmodule

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;
    localparam int ADDR_W = 21;
    localparam int DATA_W = 16;
    localparam int MINP   = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_stb = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              alg_done = 1'b0;
    logic              op_start;
    logic [2:0]        op_code;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] op_data;
    logic [1:0]        mode;

    int total = 0;
    int bad = 0;
    int n_start = 0;
    logic [2:0]        last_code = '0;
    logic [ADDR_W-1:0] last_addr = '0;
    logic [DATA_W-1:0] last_data = '0;
    int cyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE(MINP)) i_flash_cmd_decoder (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .alg_done(alg_done), .op_start(op_start), .op_code(op_code),
        .op_addr(op_addr), .op_data(op_data), .mode(mode)
    );

    always @(negedge clk) begin
        if (!rst && op_start) begin
            n_start   <= n_start + 1;
            last_code <= op_code;
            last_addr <= op_addr;
            last_data <= op_data;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !finished) begin
            finished = 1;
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: act=%0d exp<=100000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input int len);
        @(negedge clk);
        wr_addr = a; wr_data = d; wr_stb = 1'b1;
        repeat (len) @(negedge clk);
        wr_stb = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic done_pulse();
        @(negedge clk); alg_done = 1'b1;
        @(negedge clk); alg_done = 1'b0;
        @(negedge clk);
    endtask

    task automatic unlock();
        wr(21'h555, 16'h00AA, MINP);
        wr(21'h2AA, 16'h0055, MINP);
    endtask

    task automatic erase_pre();
        unlock();
        wr(21'h555, 16'h0080, MINP);
        unlock();
    endtask

    task automatic t_reset_state();
        chk("R1 mode", mode, 0);
        chk("R1 op_start", op_start, 0);
        chk("R1 op_code", op_code, 0);
    endtask

    task automatic t_program();
        int n0 = n_start;
        unlock();
        wr(21'h555, 16'h00A0, MINP);
        wr(21'h1ABCD, 16'hBEEF, MINP);
        chk("R2 one pulse", n_start - n0, 1);
        chk("R2 code", last_code, 1);
        chk("R2 addr", last_addr, 21'h1ABCD);
        chk("R2 data", last_data, 16'hBEEF);
        chk("R2 mode busy", mode, 2);
        // R10: suspend and new sequences ignored during program
        wr(21'h0, 16'h00B0, MINP);
        unlock();
        chk("R10 prog lockout pulses", n_start - n0, 1);
        chk("R10 prog lockout mode", mode, 2);
        done_pulse();
        chk("R7 done to read", mode, 0);
    endtask

    task automatic t_chip();
        int n0 = n_start;
        erase_pre();
        chk("R8 mode mid-seq", mode, 1);
        wr(21'h555, 16'h0010, MINP);
        chk("R3 one pulse", n_start - n0, 1);
        chk("R3 code", last_code, 2);
        chk("R3 mode busy", mode, 2);
        done_pulse();
        chk("R7 chip done", mode, 0);
    endtask

    task automatic t_sector_suspend();
        int n0 = n_start;
        erase_pre();
        wr(21'h0F123, 16'h0030, MINP);
        chk("R4 code", last_code, 3);
        chk("R4 addr", last_addr, 21'h0F123);
        // R10: non-suspend writes ignored while erasing
        unlock();
        wr(21'h555, 16'h00A0, MINP);
        wr(21'h00100, 16'h1234, MINP);
        chk("R10 erase lockout pulses", n_start - n0, 1);
        wr(21'h00777, 16'h00B0, MINP);
        chk("R5 code", last_code, 4);
        chk("R5 mode suspended", mode, 3);
        wr(21'h555, 16'h00F0, MINP);
        done_pulse();
        chk("R10 suspended ignores", mode, 3);
        chk("R10 suspended pulses", n_start - n0, 2);
        wr(21'h00002, 16'h0030, MINP);
        chk("R6 code", last_code, 5);
        chk("R6 mode busy", mode, 2);
        chk("R6 pulses", n_start - n0, 3);
        done_pulse();
        chk("R7 sector done", mode, 0);
    endtask

    task automatic t_reset_cmd();
        int n0 = n_start;
        unlock();
        chk("R8 mode cmd", mode, 1);
        wr(21'h0, 16'h00F0, MINP);
        chk("R8 back to read", mode, 0);
        chk("R8 no pulse", n_start - n0, 0);
    endtask

    task automatic t_broken();
        int n0 = n_start;
        wr(21'h555, 16'h00AA, MINP);
        wr(21'h2AB, 16'h0055, MINP);
        chk("R9 bad addr mode", mode, 0);
        unlock();
        wr(21'h555, 16'h0081, MINP);
        chk("R9 bad data mode", mode, 0);
        erase_pre();
        wr(21'h554, 16'h0010, MINP);
        chk("R9 chip bad addr mode", mode, 0);
        wr(21'h555, 16'h00A0, MINP);
        wr(21'h00010, 16'h0001, MINP);
        chk("R9 no pulse", n_start - n0, 0);
    endtask

    task automatic t_glitch();
        int n0 = n_start;
        wr(21'h555, 16'h00AA, MINP - 1);
        chk("R11 short strobe ignored", mode, 0);
        wr(21'h2AA, 16'h0055, MINP);
        wr(21'h555, 16'h00A0, MINP);
        wr(21'h00020, 16'h0002, MINP);
        chk("R11 no pulse after glitch", n_start - n0, 0);
        wr(21'h555, 16'h00AA, 12);
        chk("R11 long strobe one write", mode, 1);
        wr(21'h2AA, 16'h0055, 9);
        wr(21'h555, 16'h00A0, MINP);
        wr(21'h00040, 16'h4444, 20);
        chk("R11 long program pulses", n_start - n0, 1);
        done_pulse();
    endtask

    task automatic t_upper_bits();
        int n0 = n_start;
        wr(21'h555, 16'h7EAA, MINP);
        wr(21'h2AA, 16'hC355, MINP);
        wr(21'h555, 16'h01A0, MINP);
        wr(21'h00055, 16'hA5A5, MINP);
        chk("R12 pulse", n_start - n0, 1);
        chk("R12 data", last_data, 16'hA5A5);
        done_pulse();
        wr(21'h100555, 16'h00AA, MINP);
        chk("R12 full address compare", mode, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_program();
        t_chip();
        t_sector_suspend();
        t_reset_cmd();
        t_broken();
        t_glitch();
        t_upper_bits();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule